// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers every reset request in the chip and turns them into two open-drain style reset lines: a hard reset line and a soft reset line. The outputs are pull-low enables. A 1 means the block pulls the line low. A 0 means it lets go, and an external pull-up brings the line back high.

The power-on reset pin is active low and is synchronized by two flops. It keeps the block in its power-on state until the pin is released and the PLL reports lock. The block then holds both lines for a fixed stretch period. At the end of that period it captures a configuration word from the data inputs and releases the lines. After any release, a quiet window follows in which the external request inputs are not looked at.

Internal and external hard requests rerun the full hard sequence. Soft requests pull only the soft line, for a separate soft stretch period. A one-hot status register names the source of the most recent reset. Software can clear it through a write-one-to-clear input.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, both `hard_pull_low` and `soft_pull_low` are 1 and `status_q` equals 10'h001 (power-on bit only, all other bits cleared).
- R2: The power-on state is left only when the synchronized `por_n` is high and `pll_lock` is 1. While lock is 0, both outputs stay 1 however long `por_n` has been high.
- R3: On leaving the power-on state, both outputs stay 1 for exactly STRETCH_CYC cycles. With lock already true, the lines are released STRETCH_CYC+2 cycles after `por_n` rises (2 synchronizer cycles).
- R4: `mode_q` takes `mode_in` on the first cycle in which the synchronized `por_n` is high. Later changes of `mode_in` have no effect.
- R5: `cfg_word` takes `data_in` on the edge that ends the hard stretch. `cfg_strobe` is 1 for exactly the one cycle in which the hard line is first released.
- R6: In the run state, any hard request pulls both lines for exactly STRETCH_CYC cycles. Hard requests are `ext_hard_req` and `int_hard_req` bits 0 loss of lock, 1 watchdog, 2 checkstop, 3 debug hard, 4 JTAG hard.
- R7: In the run state, a soft request pulls only `soft_pull_low`, for exactly SOFT_CYC cycles. Soft requests are `ext_soft_req` and `int_soft_req` bits 0 debug soft, 1 JTAG soft.
- R8: For QUIET_CYC cycles after a release, `ext_hard_req` and `ext_soft_req` are ignored: no line is pulled and the status is unchanged. Internal requests are still accepted in this window.
- R9: `status_q` is one-hot and is rewritten on every accepted request. The bits are: 0 power-on, 1 external hard, 2 loss of lock, 3 watchdog, 4 checkstop, 5 debug hard, 6 JTAG hard, 7 external soft, 8 debug soft, 9 JTAG soft. When several requests are accepted in the same cycle, the lowest bit index wins, so a hard request beats a soft one.
- R10: A 1 on any bit of `stat_clr` clears that status bit on the next edge. Bits whose clear input is 0 are left alone.
- R11: A low level on `por_n` at any point aborts the current sequence. The outputs are asserted at once and the full power-on sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| pll_lock | input | 1 | PLL lock indication |
| ext_hard_req | input | 1 | External hard reset request (synchronous) |
| ext_soft_req | input | 1 | External soft reset request (synchronous) |
| int_hard_req | input | 5 | Internal hard requests: lock loss, watchdog, checkstop, debug, JTAG |
| int_soft_req | input | 2 | Internal soft requests: debug, JTAG |
| mode_in | input | MODE_W | Mode/clock select inputs captured at power-on release |
| data_in | input | CFG_W | Data bus sampled as configuration |
| stat_clr | input | 10 | Write-one-to-clear for the status bits |
| hard_pull_low | output | 1 | 1 = drive hard reset line low |
| soft_pull_low | output | 1 | 1 = drive soft reset line low |
| cfg_strobe | output | 1 | One-cycle pulse when the configuration word is captured |
| cfg_word | output | CFG_W | Latched configuration word |
| mode_q | output | MODE_W | Latched mode/clock select value |
| status_q | output | 10 | One-hot last-reset-source register |

## Verification
The bench builds the block with STRETCH_CYC = 64, SOFT_CYC = 24 and QUIET_CYC = 16. The stretch is shortened from its 512-cycle default so that a dozen full request sequences and several power-on sequences fit in a short run. The hard and soft lengths differ, so a pulse count alone shows which sequence ran. Even at these values, the quiet window is short next to both stretch periods. Requests placed inside it and requests placed right after it therefore fall on opposite sides of the boundary.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int N_INT_HARD = 5;
    localparam int N_INT_SOFT = 2;
    localparam int NSRC       = 2 + N_INT_HARD + N_INT_SOFT + 1;

    // status bit positions (lowest index = highest priority)
    localparam int SRC_POR      = 0;
    localparam int SRC_EXT_HARD = 1;
    localparam int SRC_INT_HARD = 2;
    localparam int SRC_EXT_SOFT = SRC_INT_HARD + N_INT_HARD;
    localparam int SRC_INT_SOFT = SRC_EXT_SOFT + 1;

    typedef enum logic [2:0] {
        ST_POR   = 3'd0,
        ST_HARD  = 3'd1,
        ST_QUIET = 3'd2,
        ST_RUN   = 3'd3,
        ST_SOFT  = 3'd4
    } rsc_state_e;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge async_n) begin
        if (!async_n) chain_q <= '0;
        else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_pick.sv
module rsc_pick #(
    parameter int N = 10
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int STRETCH_CYC = 512,
    parameter int QUIET_CYC   = 16,
    parameter int SOFT_CYC    = 512,
    parameter int CFG_W       = 32,
    parameter int MODE_W      = 3
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  pll_lock,
    input  logic                  ext_hard_req,
    input  logic                  ext_soft_req,
    input  logic [N_INT_HARD-1:0] int_hard_req,
    input  logic [N_INT_SOFT-1:0] int_soft_req,
    input  logic [MODE_W-1:0]     mode_in,
    input  logic [CFG_W-1:0]      data_in,
    input  logic [NSRC-1:0]       stat_clr,
    output logic                  hard_pull_low,
    output logic                  soft_pull_low,
    output logic                  cfg_strobe,
    output logic [CFG_W-1:0]      cfg_word,
    output logic [MODE_W-1:0]     mode_q,
    output logic [NSRC-1:0]       status_q
);

    localparam int MAX_A = (STRETCH_CYC > SOFT_CYC) ? STRETCH_CYC : SOFT_CYC;
    localparam int MAX_C = (MAX_A > QUIET_CYC) ? MAX_A : QUIET_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] STRETCH_LAST = CNT_W'(STRETCH_CYC - 1);
    localparam logic [CNT_W-1:0] QUIET_LAST   = CNT_W'(QUIET_CYC - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST    = CNT_W'(SOFT_CYC - 1);
    localparam logic [NSRC-1:0]  POR_ONLY     = NSRC'(1) << SRC_POR;

    typedef struct packed {
        rsc_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               por_prev;
        logic [NSRC-1:0]    stat;
        logic [MODE_W-1:0]  mode;
        logic [CFG_W-1:0]   cfg;
        logic               strobe;
    } rsc_regs_t;

    rsc_regs_t q_r, d_c;

    logic            por_s;
    logic [NSRC-1:0] req_v;
    logic [NSRC-1:0] pick_v;
    logic            hard_ok, ext_hard_ok, soft_ok, ext_soft_ok;
    logic            hard_hit, soft_hit;

    rsc_sync #(.STAGES(2)) u_por_sync (
        .clk     (clk),
        .async_n (por_n),
        .sync_n  (por_s)
    );

    // which request classes are looked at in the present state
    always_comb begin
        hard_ok     = (q_r.st == ST_RUN) || (q_r.st == ST_QUIET) || (q_r.st == ST_SOFT);
        ext_hard_ok = (q_r.st == ST_RUN) || (q_r.st == ST_SOFT);
        soft_ok     = (q_r.st == ST_RUN) || (q_r.st == ST_QUIET);
        ext_soft_ok = (q_r.st == ST_RUN);

        req_v                                      = '0;
        req_v[SRC_EXT_HARD]                        = ext_hard_req & ext_hard_ok & por_s;
        req_v[SRC_INT_HARD +: N_INT_HARD]          = int_hard_req & {N_INT_HARD{hard_ok & por_s}};
        req_v[SRC_EXT_SOFT]                        = ext_soft_req & ext_soft_ok & por_s;
        req_v[SRC_INT_SOFT +: N_INT_SOFT]          = int_soft_req & {N_INT_SOFT{soft_ok & por_s}};
    end

    rsc_pick #(.N(NSRC)) u_pick (
        .req   (req_v),
        .grant (pick_v)
    );

    assign hard_hit = |pick_v[SRC_EXT_SOFT-1:SRC_EXT_HARD];
    assign soft_hit = |pick_v[NSRC-1:SRC_EXT_SOFT];

    always_comb begin
        d_c          = q_r;
        d_c.strobe   = 1'b0;
        d_c.por_prev = por_s;
        d_c.stat     = q_r.stat & ~stat_clr;

        if (!por_s) begin
            d_c.st   = ST_POR;
            d_c.cnt  = '0;
            d_c.stat = POR_ONLY;
        end else begin
            unique case (q_r.st)
                ST_POR: begin
                    d_c.cnt  = '0;
                    d_c.stat = POR_ONLY;
                    if (!q_r.por_prev) d_c.mode = mode_in;
                    if (pll_lock)      d_c.st   = ST_HARD;
                end
                ST_HARD: begin
                    if (q_r.cnt == STRETCH_LAST) begin
                        d_c.st     = ST_QUIET;
                        d_c.cnt    = '0;
                        d_c.cfg    = data_in;
                        d_c.strobe = 1'b1;
                    end else begin
                        d_c.cnt = q_r.cnt + 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (hard_hit) begin
                        d_c.st  = ST_HARD;
                        d_c.cnt = '0;
                    end else if (soft_hit) begin
                        d_c.st  = ST_SOFT;
                        d_c.cnt = '0;
                    end else if (q_r.cnt == QUIET_LAST) begin
                        d_c.st  = ST_RUN;
                        d_c.cnt = '0;
                    end else begin
                        d_c.cnt = q_r.cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (hard_hit) begin
                        d_c.st  = ST_HARD;
                        d_c.cnt = '0;
                    end else if (soft_hit) begin
                        d_c.st  = ST_SOFT;
                        d_c.cnt = '0;
                    end
                end
                ST_SOFT: begin
                    if (hard_hit) begin
                        d_c.st  = ST_HARD;
                        d_c.cnt = '0;
                    end else if (q_r.cnt == SOFT_LAST) begin
                        d_c.st  = ST_QUIET;
                        d_c.cnt = '0;
                    end else begin
                        d_c.cnt = q_r.cnt + 1'b1;
                    end
                end
                default: begin
                    d_c.st  = ST_POR;
                    d_c.cnt = '0;
                end
            endcase

            if (|pick_v) d_c.stat = pick_v;
        end
    end

    always_ff @(posedge clk) begin
        q_r <= d_c;
    end

    assign hard_pull_low = !por_s || (q_r.st == ST_POR) || (q_r.st == ST_HARD);
    assign soft_pull_low = hard_pull_low || (q_r.st == ST_SOFT);
    assign cfg_strobe    = q_r.strobe;
    assign cfg_word      = q_r.cfg;
    assign mode_q        = q_r.mode;
    assign status_q      = q_r.stat;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk
    import rsc_pkg::*;
#(
    parameter int STRETCH_CYC = 512
) (
    input logic                  clk,
    input logic                  por_s,
    input rsc_state_e            st,
    input logic                  pll_lock,
    input logic [N_INT_HARD-1:0] int_hard_req,
    input logic [N_INT_SOFT-1:0] int_soft_req,
    input logic                  hard_pull_low,
    input logic                  soft_pull_low,
    input logic                  cfg_strobe,
    input logic [NSRC-1:0]       status_q
);
    int hard_run;

    always_ff @(posedge clk) begin
        if (!por_s || st != ST_HARD) hard_run <= 0;
        else                         hard_run <= hard_run + 1;
    end

    // R2: no exit from power-on state without lock
    a_r2_hold_until_lock: assert property (@(posedge clk) disable iff (!por_s)
        (st == ST_POR && !pll_lock) |=> (st == ST_POR));

    // R3: hard stretch never exceeds its length
    a_r3_stretch_bound: assert property (@(posedge clk) disable iff (!por_s)
        (st == ST_HARD) |-> (hard_run < STRETCH_CYC));

    // R5: release of the hard line coincides with the capture strobe
    a_r5_strobe_at_release: assert property (@(posedge clk) disable iff (!por_s)
        $fell(hard_pull_low) |-> cfg_strobe);

    // R8: in the quiet window only internal requests may pull a line
    a_r8_quiet_ignores_ext: assert property (@(posedge clk) disable iff (!por_s)
        (st == ST_QUIET && !(|int_hard_req) && !(|int_soft_req))
        |=> (!hard_pull_low && !soft_pull_low));

    // R9: status never holds more than one source
    a_r9_status_onehot: assert property (@(posedge clk) disable iff (!por_s)
        $onehot0(status_q));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk           (clk),
    .por_s         (por_s),
    .st            (q_r.st),
    .pll_lock      (pll_lock),
    .int_hard_req  (int_hard_req),
    .int_soft_req  (int_soft_req),
    .hard_pull_low (hard_pull_low),
    .soft_pull_low (soft_pull_low),
    .cfg_strobe    (cfg_strobe),
    .status_q      (status_q)
);

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

    localparam int STR    = 64;
    localparam int QU     = 16;
    localparam int SOF    = 24;
    localparam int CFG_W  = 32;
    localparam int MODE_W = 3;
    localparam int NV     = 12;

    // {ext_hard, int_hard[4:0], ext_soft, int_soft[1:0], expected status[9:0], hard}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 5'b00000, 1'b0, 2'b00, 10'h002, 1'b1},
        {1'b0, 5'b00001, 1'b0, 2'b00, 10'h004, 1'b1},
        {1'b0, 5'b00010, 1'b0, 2'b00, 10'h008, 1'b1},
        {1'b0, 5'b00100, 1'b0, 2'b00, 10'h010, 1'b1},
        {1'b0, 5'b01000, 1'b0, 2'b00, 10'h020, 1'b1},
        {1'b0, 5'b10000, 1'b0, 2'b00, 10'h040, 1'b1},
        {1'b0, 5'b00000, 1'b1, 2'b00, 10'h080, 1'b0},
        {1'b0, 5'b00000, 1'b0, 2'b01, 10'h100, 1'b0},
        {1'b0, 5'b00000, 1'b0, 2'b10, 10'h200, 1'b0},
        {1'b1, 5'b11111, 1'b1, 2'b11, 10'h002, 1'b1},
        {1'b0, 5'b00110, 1'b1, 2'b11, 10'h008, 1'b1},
        {1'b0, 5'b00000, 1'b0, 2'b11, 10'h100, 1'b0}
    };

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              pll_lock = 1'b0;
    logic              ext_hard_req = 1'b0;
    logic              ext_soft_req = 1'b0;
    logic [4:0]        int_hard_req = '0;
    logic [1:0]        int_soft_req = '0;
    logic [MODE_W-1:0] mode_in = '0;
    logic [CFG_W-1:0]  data_in = '0;
    logic [9:0]        stat_clr = '0;
    logic              hard_pull_low, soft_pull_low, cfg_strobe;
    logic [CFG_W-1:0]  cfg_word;
    logic [MODE_W-1:0] mode_q;
    logic [9:0]        status_q;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rst_seq_ctrl #(
        .STRETCH_CYC (STR),
        .QUIET_CYC   (QU),
        .SOFT_CYC    (SOF),
        .CFG_W       (CFG_W),
        .MODE_W      (MODE_W)
    ) u_rst_seq_ctrl (
        .clk           (clk),
        .por_n         (por_n),
        .pll_lock      (pll_lock),
        .ext_hard_req  (ext_hard_req),
        .ext_soft_req  (ext_soft_req),
        .int_hard_req  (int_hard_req),
        .int_soft_req  (int_soft_req),
        .mode_in       (mode_in),
        .data_in       (data_in),
        .stat_clr      (stat_clr),
        .hard_pull_low (hard_pull_low),
        .soft_pull_low (soft_pull_low),
        .cfg_strobe    (cfg_strobe),
        .cfg_word      (cfg_word),
        .mode_q        (mode_q),
        .status_q      (status_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        ext_hard_req = 1'b0;
        ext_soft_req = 1'b0;
        int_hard_req = '0;
        int_soft_req = '0;
    endtask

    // samples from the next falling edge until both lines are released
    task automatic count_pulls(output int nh, output int ns, output logic strb);
        nh = 0;
        ns = 0;
        @(negedge clk);
        clear_reqs();
        while ((hard_pull_low || soft_pull_low) && (nh + ns) < 4000) begin
            if (hard_pull_low) nh++;
            if (soft_pull_low) ns++;
            @(negedge clk);
        end
        strb = cfg_strobe;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int   nh, ns;
        logic sb;

        // R1: reset state while por_n is low
        idle(5);
        check("R1 hard pulled in power-on", 32'(hard_pull_low), 32'd1);
        check("R1 soft pulled in power-on", 32'(soft_pull_low), 32'd1);
        check("R1 status power-on only", 32'(status_q), 32'h001);
        check("R5 no strobe in power-on", 32'(cfg_strobe), 32'd0);

        // R2: release pin without lock, lines must stay pulled
        mode_in = 3'd5;
        data_in = 32'hA5C3_0F1E;
        por_n   = 1'b1;
        idle(4);
        mode_in = 3'd2;
        idle(36);
        check("R2 hard held without lock", 32'(hard_pull_low), 32'd1);
        check("R2 soft held without lock", 32'(soft_pull_low), 32'd1);
        pll_lock = 1'b1;
        count_pulls(nh, ns, sb);
        check("R3 hard stretch after lock", 32'(nh), 32'(STR));
        check("R3 soft stretch after lock", 32'(ns), 32'(STR));
        check("R5 strobe at release", 32'(sb), 32'd1);
        check("R5 config word captured", cfg_word, 32'hA5C3_0F1E);
        check("R4 mode captured at release", 32'(mode_q), 32'd5);
        data_in = 32'h1234_5678;
        idle(1);
        check("R5 strobe lasts one cycle", 32'(cfg_strobe), 32'd0);
        check("R5 config word held", cfg_word, 32'hA5C3_0F1E);
        idle(QU + 1);

        // R6 R7 R9: vector table in the run state
        for (int i = 0; i < NV; i++) begin
            ext_hard_req = VEC[i][19];
            int_hard_req = VEC[i][18:14];
            ext_soft_req = VEC[i][13];
            int_soft_req = VEC[i][12:11];
            count_pulls(nh, ns, sb);
            if (VEC[i][0]) begin
                check("R6 hard length", 32'(nh), 32'(STR));
                check("R6 soft during hard", 32'(ns), 32'(STR));
            end else begin
                check("R7 hard untouched by soft", 32'(nh), 32'd0);
                check("R7 soft length", 32'(ns), 32'(SOF));
            end
            check("R9 status source", 32'(status_q), 32'(VEC[i][10:1]));
            idle(QU + 2);
        end

        // R8: external requests ignored in the quiet window
        int_hard_req = 5'b00010;
        count_pulls(nh, ns, sb);
        ext_hard_req = 1'b1;
        ext_soft_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 ext hard ignored in quiet", 32'(hard_pull_low), 32'd0);
            check("R8 ext soft ignored in quiet", 32'(soft_pull_low), 32'd0);
        end
        clear_reqs();
        check("R8 status unchanged in quiet", 32'(status_q), 32'h008);
        idle(QU + 2);

        // R8: internal soft accepted inside the quiet window
        int_hard_req = 5'b00001;
        count_pulls(nh, ns, sb);
        int_soft_req = 2'b01;
        count_pulls(nh, ns, sb);
        check("R8 internal soft in quiet hard", 32'(nh), 32'd0);
        check("R8 internal soft in quiet soft", 32'(ns), 32'(SOF));
        check("R9 status debug soft", 32'(status_q), 32'h100);
        idle(QU + 2);

        // R10: write-one-to-clear
        stat_clr = 10'h001;
        @(negedge clk);
        stat_clr = '0;
        check("R10 other bit cleared no effect", 32'(status_q), 32'h100);
        stat_clr = 10'h100;
        @(negedge clk);
        stat_clr = '0;
        check("R10 set bit cleared", 32'(status_q), 32'h000);

        // R11: power-on in the middle of a hard sequence
        int_hard_req = 5'b10000;
        @(negedge clk);
        clear_reqs();
        idle(10);
        check("R11 in hard sequence", 32'(status_q), 32'h040);
        por_n = 1'b0;
        @(negedge clk);
        check("R11 hard asserted on abort", 32'(hard_pull_low), 32'd1);
        check("R11 status power-on after abort", 32'(status_q), 32'h001);
        mode_in = 3'd6;
        data_in = 32'h0BAD_F00D;
        idle(3);
        por_n = 1'b1;
        count_pulls(nh, ns, sb);
        check("R11 R3 full sequence after abort", 32'(nh), 32'(STR + 2));
        check("R11 soft full sequence", 32'(ns), 32'(STR + 2));
        check("R4 mode recaptured", 32'(mode_q), 32'd6);
        check("R5 config recaptured", cfg_word, 32'h0BAD_F00D);
        check("R1 status after power-on", 32'(status_q), 32'h001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule